// File: doc/BRIEF.md
# Flash Page Line Buffer

This block sits in front of a slow, wait-stated flash array and serves instruction fetches from one or two page-sized lines held in local storage. Each line carries a single tag, the page number, and one valid bit per flash beat. A fetch whose word is already valid returns in the next cycle. A fetch to a page that no line holds claims a line and starts a fill. The fill reads the beat holding the requested word first and then the rest of the page in wrap-around order, one 64-bit beat after another.

The flash port presents a beat address. The array returns the beat combinationally, and the block decides when to sample it. The first beat of a fill waits a programmable number of extra cycles. Every later beat of that fill takes one cycle. A fetch further into a page that is still filling redirects the fill to the wanted beat, so the beats in between do not hold the processor. A fetch to another page that is not held abandons the running fill. The beats it already loaded stay usable.

The processor port uses a request/ready pairing. The processor holds the request and the byte address until it sees ready. During that ready cycle it presents its next request, or drops the request.

Top module: `flb_line_buffer`

## Requirements
- R1: When a request hits a held page whose beat is valid, ready rises at the next clock edge. During that cycle the data output carries the 32-bit word of the flash beat. Byte address bit 2 set to 1 selects the upper half of the beat. Bits 7:3 select the beat and bits 15:8 give the page.
- R2: When a request names a page that no line holds, a line is claimed for that page. From the next cycle the flash read strobe is high and the beat address is {page, requested beat}.
- R3: A completed fill leaves all 32 beats of the line valid and lowers the flash read strobe. The word select of R1 picks the correct half of each 64-bit beat.
- R4: The first beat of a fill is sampled after wait_cfg_i + 1 cycles, and each later beat after one cycle. A miss to a new page therefore reaches ready wait_cfg_i + 3 cycles after the request is first presented.
- R5: After the critical beat, a fill continues with the next beat number and wraps from 31 to 0.
- R6: A request for a not-yet-valid beat of the page being filled makes that beat the next one read once the current beat completes. It does not wait for the beats in between.
- R7: With two lines, a new page replaces the line that was not used most recently; both hits and fills count as use. The other page stays resident.
- R8: A request to a page not held, made while a fill runs, stops that fill. Beats the stopped fill had already loaded still hit.
- R9: A request for an invalid beat of a held line that is not filling restarts a fill of that line at that beat. Beats already valid in that line stay valid.
- R10: A one-cycle invalidate pulse empties every line, so the next request to any page misses.
- R11: During reset, ready and the flash read strobe are low, and no line is held.
- R12: Hits are served while a fill is still running, and the fill carries on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| inval_i | input | 1 | Empty all lines in one cycle |
| wait_cfg_i | input | 4 | Extra cycles before the first beat of a fill |
| cpu_req_i | input | 1 | Fetch request, held until ready |
| cpu_addr_i | input | 16 | Fetch byte address |
| cpu_rdy_o | output | 1 | One-cycle pulse: data valid for the held request |
| cpu_data_o | output | 32 | Fetched word |
| fl_rd_o | output | 1 | Flash read in progress |
| fl_addr_o | output | 13 | Flash beat address |
| fl_data_i | input | 64 | Flash beat data for fl_addr_o |

## Verification
A valid bit set on a beat that was never loaded shows up as wrong data on the very next ready pulse for that word. A bit that fails to set shows up as a ready that arrives late, or never arrives. A tag or replacement error shows up as a wait on a fetch that should have hit, or as an early hit on a page that should have been evicted. Both can be seen within one cycle of the fetch. Errors in fill ordering and redirection appear on the flash beat address in the cycle after the beat that went wrong. The reference model compares that address, together with ready and data, on every clock.

// File: rtl/flb_pkg.sv
package flb_pkg;
  localparam int MAXB    = 64;
  localparam int MAXB_IW = 6;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'd0,
    ACT_NEW    = 2'd1,
    ACT_REFILL = 2'd2
  } fill_act_e;

  // First invalid beat after 'from' in wrap order; MSB flags that one exists.
  function automatic logic [MAXB_IW:0] next_gap(input logic [MAXB-1:0] vb,
                                                input int nb, input int from);
    logic [MAXB_IW:0]   res;
    logic [MAXB_IW-1:0] k;
    res = '0;
    for (int j = MAXB - 1; j >= 1; j--) begin
      if (j < nb) begin
        k = MAXB_IW'((from + j) % nb);
        if (!vb[k]) res = {1'b1, k};
      end
    end
    return res;
  endfunction
endpackage

// File: rtl/flb_way_dir.sv
module flb_way_dir #(
  parameter int NUM_WAYS = 2,
  parameter int PAGE_W   = 8,
  parameter int NB       = 32,
  parameter int BEAT_IW  = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear_i,
  input  logic [PAGE_W-1:0]  look_page_i,
  input  logic [BEAT_IW-1:0] look_beat_i,
  input  logic               start_i,
  input  logic               start_way_i,
  input  logic [PAGE_W-1:0]  start_page_i,
  input  logic               set_i,
  input  logic               set_way_i,
  input  logic [BEAT_IW-1:0] set_beat_i,
  input  logic               touch_i,
  input  logic               touch_way_i,
  input  logic               q_way_i,
  output logic [NB-1:0]      q_vb_o,
  output logic               held_o,
  output logic               held_way_o,
  output logic               word_ok_o,
  output logic               victim_o
);
  logic [NUM_WAYS-1:0] tv_w;
  logic [NUM_WAYS-1:0] hit_w;
  logic [PAGE_W-1:0]   tag_w [NUM_WAYS];
  logic [NB-1:0]       vb_w  [NUM_WAYS];

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    logic              tv;
    logic [PAGE_W-1:0] tag;
    logic [NB-1:0]     vb;
    logic              sel_set, sel_start;
    assign sel_set   = set_i   && (set_way_i   == 1'(w));
    assign sel_start = start_i && (start_way_i == 1'(w));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tv  <= 1'b0;
        tag <= '0;
        vb  <= '0;
      end else if (clear_i) begin
        tv <= 1'b0;
        vb <= '0;
      end else begin
        if (sel_set) vb[set_beat_i] <= 1'b1;
        if (sel_start) begin
          tv  <= 1'b1;
          tag <= start_page_i;
          vb  <= '0;
        end
      end
    end
    assign tv_w[w]  = tv;
    assign tag_w[w] = tag;
    assign vb_w[w]  = vb;
    assign hit_w[w] = tv && (tag == look_page_i);
  end

  always_comb begin
    held_way_o = 1'b0;
    for (int w = 0; w < NUM_WAYS; w++)
      if (hit_w[w]) held_way_o = 1'(w);
  end

  assign held_o    = |hit_w;
  assign word_ok_o = held_o && vb_w[held_way_o][look_beat_i];
  assign q_vb_o    = vb_w[q_way_i];

  if (NUM_WAYS == 2) begin : g_lru
    logic lru;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       lru <= 1'b0;
      else if (touch_i) lru <= ~touch_way_i;
    end
    assign victim_o = lru;

    // Two lines never hold the same page.
    assert_no_dup_tag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(tv_w[0] && tv_w[1] && tag_w[0] == tag_w[1]));
  end else begin : g_one
    logic unused_touch;
    assign unused_touch = touch_i ^ touch_way_i;
    assign victim_o     = 1'b0;
  end

  assert_clear_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (tv_w == '0));
endmodule

// File: rtl/flb_data_store.sv
module flb_data_store #(
  parameter int NUM_WAYS = 2,
  parameter int NB       = 32,
  parameter int BEAT_IW  = 5,
  parameter int BEAT_W   = 64,
  parameter int CPU_W    = 32,
  parameter int WSEL_W   = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we_i,
  input  logic               wr_way_i,
  input  logic [BEAT_IW-1:0] wr_beat_i,
  input  logic [BEAT_W-1:0]  wdata_i,
  input  logic               re_i,
  input  logic               rd_way_i,
  input  logic [BEAT_IW-1:0] rd_beat_i,
  input  logic [WSEL_W-1:0]  rd_sel_i,
  output logic [CPU_W-1:0]   rdata_o
);
  localparam int ENTRIES = NUM_WAYS * NB;
  localparam int IDX_W   = $clog2(ENTRIES);

  logic [BEAT_W-1:0] mem [ENTRIES];
  logic [IDX_W-1:0]  widx, ridx;

  assign widx = IDX_W'(int'(wr_way_i) * NB + int'(wr_beat_i));
  assign ridx = IDX_W'(int'(rd_way_i) * NB + int'(rd_beat_i));

  always_ff @(posedge clk) begin
    if (we_i) mem[widx] <= wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rdata_o <= '0;
    else if (re_i) rdata_o <= mem[ridx][int'(rd_sel_i) * CPU_W +: CPU_W];
  end
endmodule

// File: rtl/flb_fill_ctrl.sv
module flb_fill_ctrl
  import flb_pkg::*;
#(
  parameter int PAGE_W  = 8,
  parameter int NB      = 32,
  parameter int BEAT_IW = 5,
  parameter int WS_W    = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clear_i,
  input  fill_act_e                 act_i,
  input  logic                      act_way_i,
  input  logic [PAGE_W-1:0]         act_page_i,
  input  logic [BEAT_IW-1:0]        act_beat_i,
  input  logic [WS_W-1:0]           wait_cfg_i,
  input  logic                      want_i,
  input  logic [BEAT_IW-1:0]        want_beat_i,
  input  logic [NB-1:0]             vb_i,
  output logic                      busy_o,
  output logic                      way_o,
  output logic                      beat_done_o,
  output logic [BEAT_IW-1:0]        cur_o,
  output logic                      fl_rd_o,
  output logic [PAGE_W+BEAT_IW-1:0] fl_addr_o
);
  logic [PAGE_W-1:0]  page;
  logic [BEAT_IW-1:0] cur;
  logic [WS_W-1:0]    cnt;
  logic [NB-1:0]      vb_after;
  logic [MAXB_IW:0]   gap;
  logic               redirect;

  assign beat_done_o = busy_o && (cnt == '0);
  assign vb_after    = vb_i | (NB'(1) << cur);
  assign gap         = next_gap(MAXB'(vb_after), NB, int'(cur));
  assign redirect    = want_i && (want_beat_i != cur);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o <= 1'b0;
      way_o  <= 1'b0;
      page   <= '0;
      cur    <= '0;
      cnt    <= '0;
    end else if (clear_i) begin
      busy_o <= 1'b0;
    end else if (act_i != ACT_NONE) begin
      busy_o <= 1'b1;
      way_o  <= act_way_i;
      page   <= act_page_i;
      cur    <= act_beat_i;
      cnt    <= wait_cfg_i;
    end else if (busy_o) begin
      if (cnt != '0)         cnt <= cnt - 1'b1;
      else if (redirect)     cur <= want_beat_i;
      else if (gap[MAXB_IW]) cur <= gap[BEAT_IW-1:0];
      else                   busy_o <= 1'b0;
    end
  end

  assign cur_o     = cur;
  assign fl_rd_o   = busy_o;
  assign fl_addr_o = {page, cur};

  assert_fill_starts_at_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (act_i == ACT_NEW && !clear_i) |=>
      (fl_rd_o && fl_addr_o == {$past(act_page_i), $past(act_beat_i)}));

  assert_first_beat_waits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (act_i != ACT_NONE && !clear_i && wait_cfg_i != '0) |=> !beat_done_o);

  assert_jump_fetched_next_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_done_o && want_i && want_beat_i != cur_o && act_i == ACT_NONE && !clear_i)
      |=> (fl_addr_o[BEAT_IW-1:0] == $past(want_beat_i)));
endmodule

// File: rtl/flb_line_buffer.sv
module flb_line_buffer
  import flb_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int LINE_BYTES = 256,
  parameter int BEAT_W     = 64,
  parameter int CPU_W      = 32,
  parameter int NUM_WAYS   = 2,
  parameter int WS_W       = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                inval_i,
  input  logic [WS_W-1:0]     wait_cfg_i,
  input  logic                cpu_req_i,
  input  logic [ADDR_W-1:0]   cpu_addr_i,
  output logic                cpu_rdy_o,
  output logic [CPU_W-1:0]    cpu_data_o,
  output logic                fl_rd_o,
  output logic [ADDR_W-4:0]   fl_addr_o,
  input  logic [BEAT_W-1:0]   fl_data_i
);
  localparam int BEAT_BYTES = BEAT_W / 8;
  localparam int NB         = LINE_BYTES / BEAT_BYTES;
  localparam int BEAT_IW    = $clog2(NB);
  localparam int WPB        = BEAT_W / CPU_W;
  localparam int WSEL_W     = $clog2(WPB);
  localparam int OFS_W      = $clog2(CPU_W / 8);
  localparam int BEAT_LSB   = OFS_W + WSEL_W;
  localparam int LINE_OFS   = $clog2(LINE_BYTES);
  localparam int PAGE_W     = ADDR_W - LINE_OFS;

  // Address split
  logic [PAGE_W-1:0]  look_page;
  logic [BEAT_IW-1:0] look_beat;
  logic [WSEL_W-1:0]  look_sel;
  logic               unused_ofs;
  assign look_page  = cpu_addr_i[ADDR_W-1 -: PAGE_W];
  assign look_beat  = cpu_addr_i[BEAT_LSB +: BEAT_IW];
  assign look_sel   = cpu_addr_i[OFS_W +: WSEL_W];
  assign unused_ofs = ^cpu_addr_i[OFS_W-1:0];

  // Named internal events
  logic          held, held_way, word_ok, victim;
  logic          fill_busy, fill_way, beat_done;
  logic [BEAT_IW-1:0] fill_cur;
  logic [NB-1:0] fill_vb;
  logic          lookup_hit, miss_new, miss_gap, want;
  fill_act_e     act;
  logic          act_way;
  logic          touch, touch_way;

  assign lookup_hit = cpu_req_i && word_ok && !inval_i;
  assign miss_new   = cpu_req_i && !held && !inval_i;
  assign want       = cpu_req_i && held && !word_ok && fill_busy && (fill_way == held_way);
  assign miss_gap   = cpu_req_i && held && !word_ok && !want && !inval_i;

  always_comb begin
    if (miss_new)      act = ACT_NEW;
    else if (miss_gap) act = ACT_REFILL;
    else               act = ACT_NONE;
  end
  assign act_way   = miss_new ? victim : held_way;
  assign touch     = lookup_hit || (act != ACT_NONE);
  assign touch_way = miss_new ? victim : held_way;

  flb_way_dir #(
    .NUM_WAYS(NUM_WAYS), .PAGE_W(PAGE_W), .NB(NB), .BEAT_IW(BEAT_IW)
  ) u_dir (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear_i     (inval_i),
    .look_page_i (look_page),
    .look_beat_i (look_beat),
    .start_i     (act == ACT_NEW),
    .start_way_i (victim),
    .start_page_i(look_page),
    .set_i       (beat_done && !inval_i),
    .set_way_i   (fill_way),
    .set_beat_i  (fill_cur),
    .touch_i     (touch),
    .touch_way_i (touch_way),
    .q_way_i     (fill_way),
    .q_vb_o      (fill_vb),
    .held_o      (held),
    .held_way_o  (held_way),
    .word_ok_o   (word_ok),
    .victim_o    (victim)
  );

  flb_fill_ctrl #(
    .PAGE_W(PAGE_W), .NB(NB), .BEAT_IW(BEAT_IW), .WS_W(WS_W)
  ) u_fill (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (inval_i),
    .act_i      (act),
    .act_way_i  (act_way),
    .act_page_i (look_page),
    .act_beat_i (look_beat),
    .wait_cfg_i (wait_cfg_i),
    .want_i     (want),
    .want_beat_i(look_beat),
    .vb_i       (fill_vb),
    .busy_o     (fill_busy),
    .way_o      (fill_way),
    .beat_done_o(beat_done),
    .cur_o      (fill_cur),
    .fl_rd_o    (fl_rd_o),
    .fl_addr_o  (fl_addr_o)
  );

  flb_data_store #(
    .NUM_WAYS(NUM_WAYS), .NB(NB), .BEAT_IW(BEAT_IW),
    .BEAT_W(BEAT_W), .CPU_W(CPU_W), .WSEL_W(WSEL_W)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .we_i     (beat_done),
    .wr_way_i (fill_way),
    .wr_beat_i(fill_cur),
    .wdata_i  (fl_data_i),
    .re_i     (lookup_hit),
    .rd_way_i (held_way),
    .rd_beat_i(look_beat),
    .rd_sel_i (look_sel),
    .rdata_o  (cpu_data_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cpu_rdy_o <= 1'b0;
    else        cpu_rdy_o <= lookup_hit;
  end

  assert_ready_follows_request_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rdy_o |-> $past(cpu_req_i));

  always @(posedge clk) begin
    if (!rst_n) assert_reset_quiet_R11: assert (!cpu_rdy_o && !fl_rd_o);
  end
endmodule

// File: tb/flb_line_buffer_bench.sv
module flb_line_buffer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 32;
  localparam int NW = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        inval = 1'b0;
  logic [3:0]  wcfg = 4'd1;
  logic        req = 1'b0;
  logic [15:0] addr = '0;
  logic        rdy;
  logic [31:0] rdata;
  logic        frd;
  logic [12:0] faddr;
  logic [63:0] fdata;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  string tag = "R11";
  bit model_on = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [63:0] fword(input int b);
    logic [31:0] a;
    a = 32'(b);
    return {a ^ 32'h5A00_0000, a * 32'h0100_0193 + 32'h0000_1234};
  endfunction

  assign fdata = fword(int'(faddr));

  flb_line_buffer u_flb_line_buffer (
    .clk(clk), .rst_n(rst_n), .inval_i(inval), .wait_cfg_i(wcfg),
    .cpu_req_i(req), .cpu_addr_i(addr), .cpu_rdy_o(rdy), .cpu_data_o(rdata),
    .fl_rd_o(frd), .fl_addr_o(faddr), .fl_data_i(fdata)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // Behavioural reference model
  bit  m_tv [NW];
  int  m_tag [NW];
  bit  m_vb [NW][NB];
  int  m_lru, m_fw, m_fp, m_cb, m_cnt;
  bit  m_fa;
  bit  e_rdy;
  logic [31:0] e_data;

  task automatic m_clear();
    for (int w = 0; w < NW; w++) begin
      m_tv[w] = 0;
      for (int b = 0; b < NB; b++) m_vb[w][b] = 0;
    end
    m_fa = 0;
  endtask

  always @(posedge clk) begin
    int pg, bt, wd, hw, victim;
    bit ok, done, found;
    logic [63:0] bw;
    pg = int'(addr[15:8]); bt = int'(addr[7:3]); wd = int'(addr[2]);
    if (!rst_n) begin
      m_clear(); m_lru = 0; e_rdy = 0;
    end else if (inval) begin
      m_clear(); e_rdy = 0;
    end else begin
      hw = -1;
      for (int w = 0; w < NW; w++) if (m_tv[w] && m_tag[w] == pg) hw = w;
      ok = (hw >= 0) && m_vb[hw][bt];
      done = m_fa && (m_cnt == 0);
      e_rdy = req && ok;
      if (e_rdy) begin
        bw = fword(pg * NB + bt);
        e_data = wd ? bw[63:32] : bw[31:0];
        m_lru = 1 - hw;
      end
      if (req && hw < 0) begin
        victim = m_lru;
        if (done) m_vb[m_fw][m_cb] = 1;
        m_tv[victim] = 1; m_tag[victim] = pg;
        for (int b = 0; b < NB; b++) m_vb[victim][b] = 0;
        m_fa = 1; m_fw = victim; m_fp = pg; m_cb = bt; m_cnt = int'(wcfg);
        m_lru = 1 - victim;
      end else if (req && hw >= 0 && !ok && !(m_fa && m_fw == hw)) begin
        if (done) m_vb[m_fw][m_cb] = 1;
        m_fa = 1; m_fw = hw; m_fp = pg; m_cb = bt; m_cnt = int'(wcfg);
        m_lru = 1 - hw;
      end else if (m_fa) begin
        if (m_cnt > 0) m_cnt--;
        else begin
          m_vb[m_fw][m_cb] = 1;
          if (req && hw == m_fw && !ok && bt != m_cb) m_cb = bt;
          else begin
            found = 0;
            for (int j = 1; j < NB; j++)
              if (!found && !m_vb[m_fw][(m_cb + j) % NB]) begin
                found = 1; m_cb = (m_cb + j) % NB;
              end
            if (!found) m_fa = 0;
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (model_on && rst_n) begin
      chk(rdy == e_rdy, tag, "ready vs model", longint'(rdy), longint'(e_rdy));
      if (e_rdy) chk(rdata == e_data, tag, "data vs model", longint'(rdata), longint'(e_data));
      chk(frd == m_fa, tag, "flash strobe vs model", longint'(frd), longint'(m_fa));
      if (m_fa) chk(int'(faddr) == m_fp * NB + m_cb, tag, "flash beat address vs model",
                    longint'(faddr), longint'(m_fp * NB + m_cb));
    end
  end

  function automatic logic [15:0] mk(input int pg, input int bt, input int wd);
    return {8'(pg), 5'(bt), 1'(wd), 2'b00};
  endfunction

  task automatic rd(input logic [15:0] a, output int lat);
    req = 1'b1; addr = a; lat = 0;
    do begin @(negedge clk); lat++; end while (!rdy && lat < 300);
  endtask

  task automatic idle(input int n);
    req = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected under 100000", cyc);
      finish_run();
    end
  end

  initial begin
    int lat;
    logic [63:0] bw;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    tag = "R11";
    chk(!rdy, "R11", "ready in reset", longint'(rdy), 0);
    chk(!frd, "R11", "flash strobe in reset", longint'(frd), 0);
    rst_n = 1'b1;
    model_on = 1'b1;
    @(negedge clk);

    tag = "R2"; wcfg = 4'd1;
    rd(mk(1, 4, 0), lat);
    chk(lat == 4, "R2", "new-page miss latency", lat, 4);

    tag = "R1";
    rd(mk(1, 4, 1), lat);
    chk(lat == 1, "R1", "hit latency", lat, 1);
    bw = fword(1 * NB + 4);
    chk(rdata == bw[63:32], "R3", "upper word select", longint'(rdata), longint'(bw[63:32]));

    tag = "R5";
    rd(mk(2, 30, 0), lat);
    chk(int'(faddr) == 2 * NB + 0, "R5", "wrap to beat 0", longint'(faddr), 2 * NB);
    idle(40);
    tag = "R3";
    chk(!frd, "R3", "fill finished", longint'(frd), 0);
    rd(mk(2, 15, 1), lat);
    chk(lat == 1, "R3", "whole line valid", lat, 1);

    tag = "R6"; wcfg = 4'd3;
    rd(mk(3, 2, 0), lat);
    chk(lat == 6, "R4", "miss latency with 3 wait states", lat, 6);
    rd(mk(3, 20, 0), lat);
    chk(lat == 3, "R6", "forward jump latency", lat, 3);
    tag = "R12";
    rd(mk(3, 3, 1), lat);
    chk(lat == 1, "R12", "hit during fill", lat, 1);
    chk(frd, "R12", "fill still running", longint'(frd), 1);

    tag = "R8";
    rd(mk(4, 0, 0), lat);
    chk(lat == 6, "R8", "abort and new fill latency", lat, 6);
    rd(mk(3, 2, 0), lat);
    chk(lat == 1, "R8", "loaded beat of stopped fill hits", lat, 1);

    tag = "R9";
    req = 1'b1; addr = mk(3, 12, 0);
    @(negedge clk);
    chk(frd && int'(faddr) == 3 * NB + 12, "R9", "refill starts at gap beat",
        longint'(faddr), 3 * NB + 12);
    lat = 1;
    while (!rdy && lat < 300) begin @(negedge clk); lat++; end
    chk(lat == 6, "R9", "refill latency", lat, 6);
    rd(mk(3, 22, 0), lat);
    chk(lat == 1, "R9", "earlier beat kept", lat, 1);

    tag = "R7";
    rd(mk(5, 0, 0), lat);
    chk(lat == 6, "R7", "new page into older line", lat, 6);
    rd(mk(3, 2, 1), lat);
    chk(lat == 1, "R7", "recent page resident", lat, 1);
    rd(mk(4, 0, 0), lat);
    chk(lat == 6, "R7", "older page evicted", lat, 6);

    tag = "R10";
    req = 1'b0; inval = 1'b1;
    @(negedge clk);
    inval = 1'b0;
    rd(mk(3, 2, 0), lat);
    chk(lat == 6, "R10", "miss after invalidate", lat, 6);

    tag = "R4"; wcfg = 4'd0;
    rd(mk(6, 7, 0), lat);
    chk(lat == 3, "R4", "miss latency with no wait states", lat, 3);
    tag = "R1";
    rd(mk(6, 7, 1), lat);
    chk(lat == 1, "R1", "back-to-back hit", lat, 1);
    rd(mk(6, 7, 0), lat);
    chk(lat == 1, "R1", "back-to-back hit", lat, 1);

    idle(40);
    finish_run();
  end
endmodule